// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an eight-pin general-purpose I/O port. Software reaches it through a small register bus with a two-bit address, a write strobe, write data and combinational read data. Each pin has three bits of configuration: a direction bit, an option bit and a bit in the output latch. The direction bit makes the pin an input or an output. For an input pin, the option bit enables an interrupt on a falling edge. For an output pin, the option bit selects push-pull or open-drain drive.

The latch is written on every write to the data address, whatever the direction of the pin. A read of the data address returns a different source for each pin: the synchronized pad level for an input pin, and the latch for an output pin. Because the latch is always written, software can load the level it wants first and then turn the pin into an output. The pin then drives that level from its first cycle as an output. Pending falling-edge flags are ORed into a single interrupt request. Software clears them one bit at a time by writing 1s to a separate address.

Top module: `gpio_port`

## Requirements
- R1: Bit k of the data, direction and option registers affects only pin k. A mix of input and output pins is read back and driven bit by bit.
- R2: A direction bit of 0 makes the pin an input, and its `pin_oe` bit is 0. A direction bit of 1 makes the pin an output. Direction is at address 1 and reads back there.
- R3: For an input pin, a read of address 0 returns the pin level through a two-flop synchronizer. A change on `pin_in` appears in `rdata` after the second rising clock edge, and not after the first.
- R4: For an output pin, a read of address 0 returns the latch value, whatever the level on `pin_in`.
- R5: A write to address 0 updates the latch in every case, and `pin_out` shows the latch on the next cycle. Such a write does not enable drive on any input pin.
- R6: When a pin's direction changes from input to output, the first cycle with `pin_oe` high already drives the previously written latch value on `pin_out`.
- R7: For an input pin with its option bit set to 1, a falling edge of the synchronized level sets that pin's pending flag. A rising edge sets no flag. An option bit of 0 sets no flag. An output pin sets no flag.
- R8: `irq` is the OR of all pending flags. A read of address 3 returns the flags, with bit k for pin k.
- R9: Writing to address 3 clears each pending flag whose write-data bit is 1. Flags whose bit is 0 are left alone. Apart from this write, a flag never falls. If a new edge and a clear reach the same flag in the same cycle, the edge wins.
- R10: For an output pin, option 1 (push-pull) holds `pin_oe` high. Option 0 (open-drain) holds `pin_oe` high only while the latch bit is 0. Option is at address 2 and reads back there.
- R11: Synchronous active-high reset clears the latch, direction, option and pending bits. After reset, every pin is an undriven input, `irq` is 0, and addresses 1, 2 and 3 read back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: 0 data, 1 direction, 2 option, 3 pending/clear |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Level sampled at each pad |
| pin_out | output | 8 | Level driven to each pad |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties check on every cycle that:
- `pin_out` follows a data write on the next cycle;
- an all-zero direction write removes all drive;
- an all-zero option write never lets a pad be driven high;
- a pending flag falls only on a clear write;
- the outputs are quiet right after reset.

Only the directed scenarios can show some behaviours:
- the two-edge synchronizer latency;
- the per-pin choice of read source;
- the latch being driven on the first output cycle;
- falling-edge versus rising-edge interrupt arming;
- bit-selective clearing of the pending flags.

// File: rtl/gport_pkg.sv
package gport_pkg;

    localparam int unsigned GP_ADDR_W = 2;

    typedef enum logic [GP_ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_PEND = 2'd3
    } gp_reg_e;

    // one strobe per writable register
    typedef struct packed {
        logic data;
        logic dir;
        logic opt;
        logic clr;
    } gp_wstb_t;

    function automatic gp_wstb_t gp_decode(input logic [GP_ADDR_W-1:0] a, input logic we);
        gp_wstb_t s;
        s.data = we && (a == REG_DATA);
        s.dir  = we && (a == REG_DIR);
        s.opt  = we && (a == REG_OPT);
        s.clr  = we && (a == REG_PEND);
        return s;
    endfunction

    // output enable of one pin: output and (push-pull or latch low)
    function automatic logic gp_drive_en(input logic dir, input logic opt, input logic latch);
        return dir && (opt || !latch);
    endfunction

    // read source of one pin at the data address
    function automatic logic gp_data_bit(input logic dir, input logic latch, input logic lvl);
        return dir ? latch : lvl;
    endfunction

endpackage

// File: rtl/gport_sync.sv
module gport_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gport_regs.sv
module gport_regs
    import gport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  gp_wstb_t     wstb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] opt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            opt_q   <= '0;
        end else begin
            // latch is written regardless of direction
            if (wstb.data) latch_q <= wdata;
            if (wstb.dir)  dir_q   <= wdata;
            if (wstb.opt)  opt_q   <= wdata;
        end
    end
endmodule

// File: rtl/gport_irq.sv
module gport_irq #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] opt,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend_q
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar k = 0; k < W; k++) begin : g_pin
        logic armed;
        logic fell;
        logic clr_k;
        assign armed = !dir[k] && opt[k];
        assign fell  = prev_q[k] && !lvl[k];
        assign clr_k = clr_stb && clr_mask[k];

        always_ff @(posedge clk) begin
            if (rst)                 pend_q[k] <= 1'b0;
            else if (armed && fell)  pend_q[k] <= 1'b1;  // edge wins over clear
            else if (clr_k)          pend_q[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/gport_drive.sv
module gport_drive
    import gport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] opt,
    input  logic [W-1:0] latch,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar k = 0; k < W; k++) begin : g_pin
        assign pin_out[k] = latch[k];
        assign pin_oe[k]  = gp_drive_en(dir[k], opt[k], latch[k]);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gport_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GP_ADDR_W-1:0] addr,
    input  logic                 wr_en,
    input  logic [NPINS-1:0]     wdata,
    output logic [NPINS-1:0]     rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic                 irq
);
    gp_wstb_t         wstb;
    logic [NPINS-1:0] lvl_s;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] opt_q;
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] data_view;

    assign wstb = gp_decode(addr, wr_en);

    gport_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_s)
    );

    gport_regs #(.W(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wstb    (wstb),
        .wdata   (wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .opt_q   (opt_q)
    );

    gport_irq #(.W(NPINS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl_s),
        .dir      (dir_q),
        .opt      (opt_q),
        .clr_stb  (wstb.clr),
        .clr_mask (wdata),
        .pend_q   (pend_q)
    );

    gport_drive #(.W(NPINS)) u_drive (
        .dir     (dir_q),
        .opt     (opt_q),
        .latch   (latch_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    for (genvar k = 0; k < NPINS; k++) begin : g_view
        assign data_view[k] = gp_data_bit(dir_q[k], latch_q[k], lvl_s[k]);
    end

    always_comb begin
        unique case (gp_reg_e'(addr))
            REG_DATA: rdata = data_view;
            REG_DIR:  rdata = dir_q;
            REG_OPT:  rdata = opt_q;
            REG_PEND: rdata = pend_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = |pend_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   addr,
    input logic         wr_en,
    input logic [W-1:0] wdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic         irq,
    input logic [W-1:0] pend
);
    p_latch_out_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0) |=> (pin_out == $past(wdata)));

    p_dir_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && wdata == '0) |=> (pin_oe == '0));

    p_open_drain_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2 && wdata == '0) |=> ((pin_oe & pin_out) == '0));

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 2'd3) |=> (($past(pend) & ~pend) == '0));

    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && !irq));
endmodule

bind gpio_port gpio_port_chk #(.W(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .pend    (pend_q)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R11 oe", pin_oe, 8'h00);
        check("R11 irq", {7'd0, irq}, 8'h00);
        rd(2'd1, v); check("R11 dir", v, 8'h00);
        rd(2'd2, v); check("R11 opt", v, 8'h00);
        rd(2'd3, v); check("R11 pend", v, 8'h00);
    endtask

    task automatic t_input_sync();
        logic [7:0] v;
        pin_in = 8'hA5;
        settle(4);
        rd(2'd0, v); check("R3 input level", v, 8'hA5);
        @(negedge clk); pin_in = 8'h5A;
        @(negedge clk); #1 check("R3 one edge", rdata, 8'hA5);
        @(negedge clk); #1 check("R3 two edges", rdata, 8'h5A);
    endtask

    task automatic t_latch_as_input();
        logic [7:0] v;
        wr(2'd0, 8'h3C);
        check("R5 pin_out", pin_out, 8'h3C);
        check("R5 no drive", pin_oe, 8'h00);
        rd(2'd0, v); check("R3 still pad", v, 8'h5A);
    endtask

    task automatic t_to_output();
        logic [7:0] v;
        wr(2'd2, 8'hFF);
        @(negedge clk);
        addr = 2'd1; wdata = 8'hFF; wr_en = 1'b1;
        @(posedge clk); #1;
        check("R6 first oe", pin_oe, 8'hFF);
        check("R6 first level", pin_out, 8'h3C);
        @(negedge clk); wr_en = 1'b0;
        rd(2'd1, v); check("R2 dir readback", v, 8'hFF);
        rd(2'd0, v); check("R4 latch read", v, 8'h3C);
        check("R10 push-pull", pin_oe, 8'hFF);
    endtask

    task automatic t_mixed();
        logic [7:0] v;
        wr(2'd1, 8'h0F);
        rd(2'd0, v); check("R1 mixed read", v, 8'h5C);
        check("R1 mixed oe", pin_oe, 8'h0F);
    endtask

    task automatic t_open_drain();
        logic [7:0] v;
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R10 opt readback", v, 8'h00);
        check("R10 od oe", pin_oe, 8'hC3);
        wr(2'd0, 8'hF0);
        check("R10 od oe 2", pin_oe, 8'h0F);
        check("R10 od out", pin_out, 8'hF0);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        check("R2 input no oe", pin_oe, 8'h00);
        wr(2'd2, 8'h05);
        pin_in = 8'hFF;
        settle(5);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); check("R7 rise no flag", v, 8'h00);
        check("R8 irq low", {7'd0, irq}, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        settle(5);
        rd(2'd3, v); check("R7 armed falls", v, 8'h05);
        check("R8 irq high", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h01);
        rd(2'd3, v); check("R9 clear bit0", v, 8'h04);
        check("R8 irq still", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h04);
        check("R9 irq cleared", {7'd0, irq}, 8'h00);
        pin_in = 8'hFF;
        settle(5);
        rd(2'd3, v); check("R7 rising ignored", v, 8'h00);
    endtask

    initial begin
        settle(3);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_input_sync();
        t_latch_as_input();
        t_to_output();
        t_mixed();
        t_open_drain();
        t_irq();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule